// File: doc/BRIEF.md
# Variable Pulse Width Frame Receiver

This block turns the filtered level of a single-wire variable-pulse-width bus into received bytes. It times every active and every passive level period in microsecond ticks and sorts it into a symbol class: start-of-frame, data 0, data 1, or invalid. A passive period that grows long enough marks end-of-data and then end-of-frame. Decoded bits are packed most significant bit first. When end-of-data is reached, the block checks the byte count, the byte alignment and the trailing CRC byte.

A bit's value depends on both the level and the length of its period. A short passive or long active period carries a 0. A long passive or short active period carries a 1. The period counter saturates, so the timing windows are plain compare constants. The block only receives. Periods on the bus after end-of-data, such as a responder's reply, are passed over until end-of-frame or the next start-of-frame.

Top module: `vpw_rx`

## Requirements
- R1: The first frame after reset starts only on an active period of SOF_MIN..SOF_MAX ticks (default 164..239). No byte and no frame-done appear before that.
- R2: Inside a frame, a passive period of SHORT_MIN..SHORT_MAX ticks (34..96) decodes as 0 and one of SHORT_MAX+1..LONG_MAX ticks (97..163) decodes as 1. An active period of 34..96 ticks decodes as 1 and one of 97..163 ticks decodes as 0.
- R3: Bits are packed most significant bit first. After every eighth bit, byte_vld_o pulses for one cycle and byte_o holds the completed byte.
- R4: A passive period that reaches EOD_MIN ticks (164) inside a frame ends the data. frame_done_o then pulses for one cycle, never in the same cycle as byte_vld_o.
- R5: At frame_done_o, crc_err_o is high when the last byte is not the inverted CRC-8 of all earlier bytes. The CRC uses polynomial 0x1D, is preset to 0xFF and is shifted MSB first. A correct frame leaves register residue 0xC4.
- R6: At frame_done_o, len_err_o is high when the frame holds fewer than 2 bytes, ends on a partial byte, or holds more than MAX_BYTES (12) bytes. Bytes beyond MAX_BYTES are not strobed. crc_err_o stays low whenever len_err_o is high.
- R7: sym_err_o pulses on any in-frame period shorter than SHORT_MIN, and on any in-frame active period longer than LONG_MAX. On an idle bus it pulses on any active period outside the start-of-frame window. The frame is then abandoned with no frame-done, and the block waits for end-of-frame.
- R8: After end-of-data or an abandoned frame, active periods outside the start-of-frame window raise no flag and give no byte. A passive period of EOF_MIN ticks (240) returns the block to idle.
- R9: While reset is asserted and right after it, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse every microsecond |
| bus_i | input | 1 | Filtered bus level, 1 = active |
| byte_vld_o | output | 1 | Received byte strobe |
| byte_o | output | 8 | Received byte, valid with byte_vld_o |
| frame_done_o | output | 1 | End-of-data reached for a frame |
| crc_err_o | output | 1 | CRC mismatch, valid with frame_done_o |
| len_err_o | output | 1 | Byte count or alignment error, valid with frame_done_o |
| sym_err_o | output | 1 | Invalid symbol pulse |

## Verification
The bench builds the block with its default windows and a MAX_BYTES of 12. It drives the tick every second clock, so a full 12-byte frame and a 13-byte overrun frame both fit in a short run. All nominal symbol lengths sit well inside their windows. The error cases use clearly short (20 µs) and clearly long (250 µs) periods, so a one-tick measuring uncertainty cannot change any expected result. A scoreboard matches each byte, each frame-done with its two flags, and each invalid-symbol pulse in order.

// File: rtl/vpw_rx_pkg.sv
package vpw_rx_pkg;
  typedef enum logic [1:0] {SYM_BAD, SYM_D0, SYM_D1, SYM_SOF} sym_e;
  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_TAIL} st_e;

  localparam logic [7:0] CRC_POLY    = 8'h1D;
  localparam logic [7:0] CRC_PRESET  = 8'hFF;
  localparam logic [7:0] CRC_RESIDUE = 8'hC4;

  function automatic logic [7:0] crc_step(logic [7:0] c, logic b);
    logic fb;
    fb = c[7] ^ b;
    return {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
  endfunction
endpackage

// File: rtl/vpw_rx_timer.sv
module vpw_rx_timer #(
  parameter int EOD_MIN = 164,
  parameter int EOF_MIN = 240,
  parameter int CNT_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             bus_i,
  output logic             per_vld_o,
  output logic             per_act_o,
  output logic [CNT_W-1:0] per_len_o,
  output logic             eod_o,
  output logic             eof_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] EOD_M1  = CNT_W'(EOD_MIN - 1);
  localparam logic [CNT_W-1:0] EOF_M1  = CNT_W'(EOF_MIN - 1);

  logic             bus_q;
  logic [CNT_W-1:0] cnt_q;
  logic             edge_s;
  logic             grow_s;

  assign edge_s = bus_i ^ bus_q;
  assign grow_s = !edge_s && tick_i && !bus_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_q     <= 1'b0;
      cnt_q     <= CNT_SAT;
      per_vld_o <= 1'b0;
      per_act_o <= 1'b0;
      per_len_o <= '0;
      eod_o     <= 1'b0;
      eof_o     <= 1'b0;
    end else begin
      bus_q     <= bus_i;
      per_vld_o <= edge_s;
      per_act_o <= bus_q;
      per_len_o <= cnt_q;
      eod_o     <= grow_s && (cnt_q == EOD_M1);
      eof_o     <= grow_s && (cnt_q == EOF_M1);
      if (edge_s)                         cnt_q <= '0;
      else if (tick_i && cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/vpw_rx_classify.sv
module vpw_rx_classify
  import vpw_rx_pkg::*;
#(
  parameter int SHORT_MIN = 34,
  parameter int SHORT_MAX = 96,
  parameter int LONG_MAX  = 163,
  parameter int SOF_MAX   = 239,
  parameter int CNT_W     = 8
) (
  input  logic             act_i,
  input  logic [CNT_W-1:0] len_i,
  output sym_e             sym_o
);
  localparam logic [CNT_W-1:0] L_SMIN = CNT_W'(SHORT_MIN);
  localparam logic [CNT_W-1:0] L_SMAX = CNT_W'(SHORT_MAX);
  localparam logic [CNT_W-1:0] L_LMAX = CNT_W'(LONG_MAX);
  localparam logic [CNT_W-1:0] L_FMAX = CNT_W'(SOF_MAX);

  always_comb begin
    if (len_i < L_SMIN)       sym_o = SYM_BAD;
    else if (len_i <= L_SMAX) sym_o = act_i ? SYM_D1 : SYM_D0;
    else if (len_i <= L_LMAX) sym_o = act_i ? SYM_D0 : SYM_D1;
    else if (act_i && len_i <= L_FMAX) sym_o = SYM_SOF;
    else                      sym_o = SYM_BAD;
  end
endmodule

// File: rtl/vpw_rx_deframe.sv
module vpw_rx_deframe
  import vpw_rx_pkg::*;
#(
  parameter int MAX_BYTES = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       per_vld_i,
  input  logic       per_act_i,
  input  sym_e       sym_i,
  input  logic       eod_i,
  input  logic       eof_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       frame_done_o,
  output logic       crc_err_o,
  output logic       len_err_o,
  output logic       sym_err_o
);
  localparam int BC_W = $clog2(MAX_BYTES + 2);
  localparam logic [BC_W-1:0] BC_MAX = BC_W'(MAX_BYTES + 1);
  localparam logic [BC_W-1:0] BC_LIM = BC_W'(MAX_BYTES);
  localparam logic [BC_W-1:0] BC_MIN = BC_W'(2);

  st_e             st_q;
  logic [6:0]      sh_q;
  logic [2:0]      bit_q;
  logic [BC_W-1:0] nbyte_q;
  logic [7:0]      crc_q;
  logic            is_bit, bit_val, len_bad, sof_seen;

  assign is_bit   = (sym_i == SYM_D0) || (sym_i == SYM_D1);
  assign bit_val  = (sym_i == SYM_D1);
  assign sof_seen = per_vld_i && per_act_i && (sym_i == SYM_SOF);
  assign len_bad  = (bit_q != 3'd0) || (nbyte_q < BC_MIN) || (nbyte_q > BC_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      sh_q         <= '0;
      bit_q        <= '0;
      nbyte_q      <= '0;
      crc_q        <= CRC_PRESET;
      byte_vld_o   <= 1'b0;
      byte_o       <= '0;
      frame_done_o <= 1'b0;
      crc_err_o    <= 1'b0;
      len_err_o    <= 1'b0;
      sym_err_o    <= 1'b0;
    end else begin
      byte_vld_o   <= 1'b0;
      frame_done_o <= 1'b0;
      crc_err_o    <= 1'b0;
      len_err_o    <= 1'b0;
      sym_err_o    <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (sof_seen) begin
            st_q    <= ST_DATA;
            bit_q   <= '0;
            nbyte_q <= '0;
            crc_q   <= CRC_PRESET;
          end else if (per_vld_i && per_act_i) begin
            sym_err_o <= 1'b1;
            st_q      <= ST_TAIL;
          end
        end
        ST_DATA: begin
          if (per_vld_i) begin
            if (is_bit) begin
              sh_q  <= {sh_q[5:0], bit_val};
              crc_q <= crc_step(crc_q, bit_val);
              bit_q <= bit_q + 3'd1;
              if (bit_q == 3'd7) begin
                if (nbyte_q < BC_LIM) begin
                  byte_vld_o <= 1'b1;
                  byte_o     <= {sh_q, bit_val};
                end
                if (nbyte_q != BC_MAX) nbyte_q <= nbyte_q + 1'b1;
              end
            end else begin
              sym_err_o <= 1'b1;
              st_q      <= ST_TAIL;
            end
          end else if (eod_i) begin
            frame_done_o <= 1'b1;
            len_err_o    <= len_bad;
            crc_err_o    <= !len_bad && (crc_q != CRC_RESIDUE);
            st_q         <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (sof_seen) begin
            st_q    <= ST_DATA;
            bit_q   <= '0;
            nbyte_q <= '0;
            crc_q   <= CRC_PRESET;
          end else if (eof_i) begin
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vpw_rx.sv
module vpw_rx
  import vpw_rx_pkg::*;
#(
  parameter int SHORT_MIN = 34,
  parameter int SHORT_MAX = 96,
  parameter int LONG_MAX  = 163,
  parameter int SOF_MAX   = 239,
  parameter int EOD_MIN   = 164,
  parameter int EOF_MIN   = 240,
  parameter int MAX_BYTES = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       bus_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       frame_done_o,
  output logic       crc_err_o,
  output logic       len_err_o,
  output logic       sym_err_o
);
  localparam int CNT_W = $clog2(EOF_MIN + 1);

  logic             per_vld, per_act, eod, eof;
  logic [CNT_W-1:0] per_len;
  sym_e             sym;

  vpw_rx_timer #(.EOD_MIN(EOD_MIN), .EOF_MIN(EOF_MIN), .CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .bus_i(bus_i),
    .per_vld_o(per_vld), .per_act_o(per_act), .per_len_o(per_len),
    .eod_o(eod), .eof_o(eof)
  );

  vpw_rx_classify #(
    .SHORT_MIN(SHORT_MIN), .SHORT_MAX(SHORT_MAX), .LONG_MAX(LONG_MAX),
    .SOF_MAX(SOF_MAX), .CNT_W(CNT_W)
  ) u_class (
    .act_i(per_act), .len_i(per_len), .sym_o(sym)
  );

  vpw_rx_deframe #(.MAX_BYTES(MAX_BYTES)) u_deframe (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .per_vld_i(per_vld), .per_act_i(per_act), .sym_i(sym),
    .eod_i(eod), .eof_i(eof),
    .byte_vld_o(byte_vld_o), .byte_o(byte_o), .frame_done_o(frame_done_o),
    .crc_err_o(crc_err_o), .len_err_o(len_err_o), .sym_err_o(sym_err_o)
  );
endmodule

// File: rtl/vpw_rx_chk.sv
module vpw_rx_chk #(
  parameter int MAX_BYTES = 12
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       byte_vld_o,
  input logic [7:0] byte_o,
  input logic       frame_done_o,
  input logic       crc_err_o,
  input logic       len_err_o,
  input logic       sym_err_o
);
  localparam int SW = $clog2(MAX_BYTES + 2);
  logic [SW-1:0] seen_q;
  logic [7:0]    unused_byte;
  assign unused_byte = byte_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else if (frame_done_o || sym_err_o) seen_q <= '0;
    else if (byte_vld_o) seen_q <= seen_q + 1'b1;
  end

  p_done_not_byte_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> !byte_vld_o);
  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);
  p_crc_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_o |-> (frame_done_o && !len_err_o));
  p_len_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_err_o |-> frame_done_o);
  p_byte_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> (seen_q < SW'(MAX_BYTES)));
  p_sym_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_err_o |-> (!frame_done_o && !byte_vld_o));
endmodule

bind vpw_rx vpw_rx_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .byte_vld_o(byte_vld_o), .byte_o(byte_o),
  .frame_done_o(frame_done_o), .crc_err_o(crc_err_o), .len_err_o(len_err_o),
  .sym_err_o(sym_err_o)
);

// File: tb/vpw_rx_tb.sv
module vpw_rx_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       bus_i = 1'b0;
  logic       byte_vld_o, frame_done_o, crc_err_o, len_err_o, sym_err_o;
  logic [7:0] byte_o;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    int         kind;  // 0 byte, 1 done, 2 invalid symbol
    logic [7:0] d;
    logic       crc;
    logic       len;
    string      req;
  } exp_t;
  exp_t       q[$];
  logic [7:0] pl [16];
  logic       cur_act;

  vpw_rx u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .bus_i(bus_i),
    .byte_vld_o(byte_vld_o), .byte_o(byte_o), .frame_done_o(frame_done_o),
    .crc_err_o(crc_err_o), .len_err_o(len_err_o), .sym_err_o(sym_err_o)
  );

  always #5 clk_i = ~clk_i;

  initial forever begin
    @(negedge clk_i);
    tick_i = ~tick_i;
  end

  task automatic check(string req, bit ok, string act, string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic push(int kind, logic [7:0] d, logic crc, logic len, string req);
    exp_t e;
    e.kind = kind; e.d = d; e.crc = crc; e.len = len; e.req = req;
    q.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && (byte_vld_o || frame_done_o || sym_err_o)) begin
      if (q.size() == 0) begin
        check("R8", 1'b0, $sformatf("evt b%0d d%0d s%0d", byte_vld_o, frame_done_o, sym_err_o), "none");
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.kind == 0)
          check(e.req, byte_vld_o && !frame_done_o && !sym_err_o && byte_o == e.d,
                $sformatf("b%0d %h", byte_vld_o, byte_o), $sformatf("byte %h", e.d));
        else if (e.kind == 1)
          check(e.req, frame_done_o && crc_err_o == e.crc && len_err_o == e.len,
                $sformatf("done%0d crc%0d len%0d", frame_done_o, crc_err_o, len_err_o),
                $sformatf("done1 crc%0d len%0d", e.crc, e.len));
        else
          check(e.req, sym_err_o && !byte_vld_o && !frame_done_o,
                $sformatf("sym%0d", sym_err_o), "sym1");
      end
    end
  end

  task automatic hold(logic lvl, int n);
    @(negedge clk_i);
    bus_i = lvl;
    for (int k = 0; k < n; ) begin
      @(posedge clk_i);
      if (tick_i) k++;
    end
  endtask

  task automatic put_bit(logic b);
    int dur;
    if (cur_act) dur = b ? 64 : 128;
    else         dur = b ? 128 : 64;
    hold(cur_act, dur);
    cur_act = !cur_act;
  endtask

  task automatic put_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
  endtask

  task automatic sof();
    hold(1'b1, 200);
    cur_act = 1'b0;
  endtask

  function automatic logic [7:0] crc8(int m);
    logic [7:0] c;
    logic       fb;
    c = 8'hFF;
    for (int i = 0; i < m; i++)
      for (int j = 7; j >= 0; j--) begin
        fb = c[7] ^ pl[i][j];
        c = {c[6:0], 1'b0};
        if (fb) c = c ^ 8'h1D;
      end
    return ~c;
  endfunction

  // m payload bytes from pl, then CRC byte (optionally corrupted)
  task automatic send_frame(int m, bit corrupt, string req);
    logic [7:0] cb;
    int         tot;
    bit         lbad;
    cb   = crc8(m) ^ (corrupt ? 8'h01 : 8'h00);
    tot  = m + 1;
    lbad = (tot < 2) || (tot > 12);
    for (int i = 0; i < m && i < 12; i++) push(0, pl[i], 0, 0, "R3");
    if (tot <= 12) push(0, cb, 0, 0, "R2");
    push(1, 8'h00, !lbad && corrupt, lbad, req);
    sof();
    for (int i = 0; i < m; i++) put_byte(pl[i]);
    put_byte(cb);
    hold(1'b0, 300);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R9", !byte_vld_o && !frame_done_o && !crc_err_o && !len_err_o && !sym_err_o,
          "outputs in reset", "all low");
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    check("R9", !byte_vld_o && !frame_done_o && !sym_err_o, "outputs after reset", "all low");

    // R1: a non-start active period on the idle bus decodes nothing
    push(2, 0, 0, 0, "R1");
    hold(1'b1, 64); hold(1'b0, 300);

    // R2 R3 R5: good 3+1 byte frame
    pl[0] = 8'h61; pl[1] = 8'h6A; pl[2] = 8'hF1;
    send_frame(3, 0, "R5");

    // R6: exactly 12 bytes, no error
    for (int i = 0; i < 11; i++) pl[i] = 8'(i * 37 + 5);
    send_frame(11, 0, "R6");

    // R6: 13 bytes, overrun
    for (int i = 0; i < 12; i++) pl[i] = 8'(8'hF0 - i);
    send_frame(12, 0, "R6");

    // R5: corrupted CRC
    pl[0] = 8'h00; pl[1] = 8'hFF;
    send_frame(2, 1, "R5");

    // R6: CRC byte only
    send_frame(0, 0, "R6");

    // R6: partial byte
    push(0, 8'hA5, 0, 0, "R3");
    push(1, 0, 0, 1, "R6");
    sof(); put_byte(8'hA5);
    for (int i = 0; i < 4; i++) put_bit(i[0]);
    hold(1'b0, 300);

    // R7: too-short active pulse inside a frame
    push(2, 0, 0, 0, "R7");
    sof(); put_bit(1); put_bit(0); put_bit(1);
    hold(1'b1, 20); hold(1'b0, 300);

    // R7: too-long active pulse inside a frame
    push(2, 0, 0, 0, "R7");
    sof(); put_bit(0);
    hold(1'b1, 250); hold(1'b0, 300);

    // R7: noise pulse on idle bus
    push(2, 0, 0, 0, "R7");
    hold(1'b1, 20); hold(1'b0, 300);

    // R4 R8: pulse after end-of-data is ignored
    pl[0] = 8'h3C;
    begin
      logic [7:0] cb;
      cb = crc8(1);
      push(0, 8'h3C, 0, 0, "R3");
      push(0, cb, 0, 0, "R2");
      push(1, 0, 0, 0, "R4");
      sof(); put_byte(8'h3C); put_byte(cb);
      hold(1'b0, 180); hold(1'b1, 64); hold(1'b0, 300);
    end

    repeat (20) @(negedge clk_i);
    check("R8", q.size() == 0, $sformatf("%0d pending", q.size()), "0 pending");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule